// File: doc/BRIEF.md
# Ethernet MAC Interrupt Event Unit

This block keeps the event status word and the event enable word of a fast Ethernet MAC, and drives thirteen separate level interrupt lines from the events that are both pending and enabled. The MAC's datapath engines (transmit, receive, DMA, PHY management) report events through single-cycle set pulses. Software sees the pending events and the enables through a small register port. It acknowledges events by writing ones to the status word and programs the enable word directly.

Three register writes have side effects on the event state. Writing the PHY management frame register raises the management-done event. Writing the transmit control register with bit 0 set raises the graceful-stop event at once. Writing the controller control register with bit 0 set wipes both the status and the enable word. The register port has a single shared address: writes take effect at the clock edge, and reads are combinational from the addressed register.

Top module: `ievt_unit`

## Requirements
- R1: `evt_set[k]` sets status bit 19+k at the next clock edge. The event index k runs, from 12 down to 0: heartbeat, babbling receive, babbling transmit, graceful-stop, tx frame, tx buffer, rx frame, rx buffer, management done, bus error, late collision, retry limit, tx underrun. Reading address 0 returns the status with bits 18:0 zero.
- R2: A write to address 0 clears every status bit written as one and leaves all other status bits unchanged.
- R3: A write to address 1 loads the enable word. Only bits 31:19 are kept, and a read of address 1 returns them with bits 18:0 zero.
- R4: `irq[n]` for n = 0..12 is driven by event index 8, 7, 0, 1, 6, 5, 4, 2, 12, 9, 3, 10, 11 respectively. A line is high only when that event's status bit and enable bit are both set.
- R5: Each `irq` line is registered and follows its enabled-status term one clock after the status or enable changes.
- R6: When a set pulse and a clear-by-write hit the same status bit in one cycle, the bit ends up set.
- R7: Any write to address 2 (management frame register) sets the management-done event (status bit 23).
- R8: A write to address 3 (transmit control) with bit 0 set sets the graceful-stop event (status bit 28). With bit 0 clear, the write leaves the status unchanged.
- R9: A write to address 4 (controller control) with bit 0 set clears the status and the enable word, overriding set pulses in the same cycle. With bit 0 clear, the write changes neither.
- R10: After reset, the status, the enable word and every `irq` line are zero.
- R11: Reads of addresses 2 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Register word address (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| evt_set | input | 13 | Event set pulses, index as in R1 |
| irq | output | 13 | Level interrupt lines, order as in R4 |

## Verification
A status bit that is wrongly held or wrongly dropped is visible on the status read in the cycle right after the edge that should have changed it. It shows on the mapped `irq` line one clock later. A wrong line mapping only shows when a single event is pending with all enables on, so every event is raised alone and the line it reaches is checked. Same-cycle set-and-clear and control-reset-versus-set races are driven directly, because those collisions leave no trace except the final status value.

// File: rtl/ievt_pkg.sv
package ievt_pkg;

    localparam int unsigned N_EVT = 13;

    typedef logic [N_EVT-1:0] evt_vec_t;

    // Event index k maps to status bit (DATA_W - N_EVT + k)
    typedef enum int unsigned {
        EV_UNDERRUN = 0,
        EV_RETRY    = 1,
        EV_LATECOL  = 2,
        EV_BUSERR   = 3,
        EV_MGMT     = 4,
        EV_RXBUF    = 5,
        EV_RXFRM    = 6,
        EV_TXBUF    = 7,
        EV_TXFRM    = 8,
        EV_GSTOP    = 9,
        EV_BABTX    = 10,
        EV_BABRX    = 11,
        EV_HEART    = 12
    } evt_idx_e;

    // Which event index feeds each interrupt line
    function automatic int unsigned line_src(input int unsigned line);
        case (line)
            0:       line_src = EV_TXFRM;
            1:       line_src = EV_TXBUF;
            2:       line_src = EV_UNDERRUN;
            3:       line_src = EV_RETRY;
            4:       line_src = EV_RXFRM;
            5:       line_src = EV_RXBUF;
            6:       line_src = EV_MGMT;
            7:       line_src = EV_LATECOL;
            8:       line_src = EV_HEART;
            9:       line_src = EV_GSTOP;
            10:      line_src = EV_BUSERR;
            11:      line_src = EV_BABTX;
            default: line_src = EV_BABRX;
        endcase
    endfunction

    typedef struct packed {
        evt_vec_t mask;
    } regif_state_t;

    typedef struct packed {
        evt_vec_t status;
    } stat_state_t;

    typedef struct packed {
        evt_vec_t lines;
    } line_state_t;

endpackage

// File: rtl/ievt_regif.sv
module ievt_regif
    import ievt_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned A_STATUS = 0,
    parameter int unsigned A_MASK   = 1,
    parameter int unsigned A_MGMT   = 2,
    parameter int unsigned A_TXCTL  = 3,
    parameter int unsigned A_CTRL   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output evt_vec_t          clr_bits,
    output logic              clr_all,
    output evt_vec_t          side_set,
    output evt_vec_t          mask_q
);

    localparam int unsigned EV_LSB = DATA_W - N_EVT;

    regif_state_t st_d, st_q;
    logic hit_status, hit_mask, hit_mgmt, hit_txctl, hit_ctrl;

    always_comb begin
        hit_status = wr_en && (wr_addr == ADDR_W'(A_STATUS));
        hit_mask   = wr_en && (wr_addr == ADDR_W'(A_MASK));
        hit_mgmt   = wr_en && (wr_addr == ADDR_W'(A_MGMT));
        hit_txctl  = wr_en && (wr_addr == ADDR_W'(A_TXCTL));
        hit_ctrl   = wr_en && (wr_addr == ADDR_W'(A_CTRL));

        clr_bits = hit_status ? wr_data[DATA_W-1:EV_LSB] : '0;
        clr_all  = hit_ctrl && wr_data[0];

        side_set = '0;
        side_set[EV_MGMT]  = hit_mgmt;
        side_set[EV_GSTOP] = hit_txctl && wr_data[0];

        st_d = st_q;
        if (clr_all) begin
            st_d.mask = '0;
        end else if (hit_mask) begin
            st_d.mask = wr_data[DATA_W-1:EV_LSB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q = st_q.mask;

    AST_MASK_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(A_CTRL) && wr_data[0]) |=> (mask_q == '0)); // R9

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(A_MASK))
        |=> (mask_q == $past(wr_data[DATA_W-1:EV_LSB]))); // R3

endmodule

// File: rtl/ievt_status.sv
module ievt_status
    import ievt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  evt_vec_t set_vec,
    input  evt_vec_t clr_bits,
    input  logic     clr_all,
    output evt_vec_t status_q
);

    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_all) begin
            st_d.status = '0;
        end else begin
            // a set pulse outranks a same-cycle clear
            st_d.status = (st_q.status & ~clr_bits) | set_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_q = st_q.status;

    AST_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all && (set_vec != '0)) |=> ((status_q & $past(set_vec)) == $past(set_vec))); // R6

    AST_ONLY_CLEARED_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_all |=> ((($past(status_q) & ~status_q) & ~$past(clr_bits)) == '0)); // R2

    AST_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (status_q == '0)); // R9

endmodule

// File: rtl/ievt_linemap.sv
module ievt_linemap
    import ievt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  evt_vec_t status,
    input  evt_vec_t mask,
    output evt_vec_t irq_q
);

    evt_vec_t    active;
    evt_vec_t    routed;
    line_state_t st_d, st_q;

    assign active = status & mask;

    for (genvar g = 0; g < N_EVT; g++) begin : g_line
        assign routed[g] = active[line_src(g)];
    end

    always_comb begin
        st_d = st_q;
        st_d.lines = routed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_q = st_q.lines;

    AST_QUIET_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |=> (irq_q == '0)); // R5

    AST_LINE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(irq_q) == $countones($past(active)))); // R4

endmodule

// File: rtl/ievt_unit.sv
module ievt_unit
    import ievt_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned A_STATUS = 0,
    parameter int unsigned A_MASK   = 1,
    parameter int unsigned A_MGMT   = 2,
    parameter int unsigned A_TXCTL  = 3,
    parameter int unsigned A_CTRL   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_EVT-1:0]  evt_set,
    output logic [N_EVT-1:0]  irq
);

    localparam int unsigned EV_LSB = DATA_W - N_EVT;

    evt_vec_t clr_bits, side_set, mask_q, status_q;
    logic     clr_all;

    ievt_regif #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .A_STATUS (A_STATUS),
        .A_MASK   (A_MASK),
        .A_MGMT   (A_MGMT),
        .A_TXCTL  (A_TXCTL),
        .A_CTRL   (A_CTRL)
    ) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_addr  (reg_addr),
        .wr_data  (reg_wdata),
        .clr_bits (clr_bits),
        .clr_all  (clr_all),
        .side_set (side_set),
        .mask_q   (mask_q)
    );

    ievt_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (evt_set | side_set),
        .clr_bits (clr_bits),
        .clr_all  (clr_all),
        .status_q (status_q)
    );

    ievt_linemap u_lines (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status_q),
        .mask   (mask_q),
        .irq_q  (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_STATUS)) begin
            reg_rdata[DATA_W-1:EV_LSB] = status_q;
        end else if (reg_addr == ADDR_W'(A_MASK)) begin
            reg_rdata[DATA_W-1:EV_LSB] = mask_q;
        end
    end

    AST_MGMT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(A_MGMT)) |=> status_q[EV_MGMT]); // R7

    AST_GSTOP_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(A_TXCTL) && reg_wdata[0]) |=> status_q[EV_GSTOP]); // R8

    AST_PULSE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set[EV_HEART] && !(reg_wr && reg_addr == ADDR_W'(A_CTRL) && reg_wdata[0]))
        |=> reg_rdata[DATA_W-1] || (reg_addr != ADDR_W'(A_STATUS))); // R1

endmodule

// File: tb/ievt_unit_test.sv
module ievt_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [12:0] evt_set = '0;
    logic [12:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    ievt_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_set   (evt_set),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {event pulse, enable bits 31:19, expected irq lines}
    localparam logic [38:0] VEC [16] = '{
        {13'h0100, 13'h1FFF, 13'h0001},
        {13'h0080, 13'h1FFF, 13'h0002},
        {13'h0001, 13'h1FFF, 13'h0004},
        {13'h0002, 13'h1FFF, 13'h0008},
        {13'h0040, 13'h1FFF, 13'h0010},
        {13'h0020, 13'h1FFF, 13'h0020},
        {13'h0010, 13'h1FFF, 13'h0040},
        {13'h0004, 13'h1FFF, 13'h0080},
        {13'h1000, 13'h1FFF, 13'h0100},
        {13'h0200, 13'h1FFF, 13'h0200},
        {13'h0008, 13'h1FFF, 13'h0400},
        {13'h0400, 13'h1FFF, 13'h0800},
        {13'h0800, 13'h1FFF, 13'h1000},
        {13'h1FFF, 13'h0000, 13'h0000},
        {13'h1FFF, 13'h0100, 13'h0001},
        {13'h1FFF, 13'h1FFF, 13'h1FFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [12:0] e);
        @(negedge clk);
        evt_set = e;
        @(negedge clk);
        evt_set = '0;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R10 reset state
        rd(4'd0, v); check("R10 status", v, 32'h0);
        rd(4'd1, v); check("R10 mask", v, 32'h0);
        check("R10 irq", {19'b0, irq}, 32'h0);
        rst_n = 1'b1;

        // R4 mapping / R1 set pulses, walked from the table
        for (int i = 0; i < 16; i++) begin
            wr(4'd0, 32'hFFFF_FFFF);
            wr(4'd1, {VEC[i][25:13], 19'b0});
            pulse(VEC[i][38:26]);
            rd(4'd0, v); check("R1 status set", v, {VEC[i][38:26], 19'b0});
            @(negedge clk);
            check("R4 irq lines", {19'b0, irq}, {19'b0, VEC[i][12:0]});
        end

        // R5 one-cycle lag
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd1, 32'hFFFF_FFFF);
        @(negedge clk);
        pulse(13'h0100);
        check("R5 irq not yet", {19'b0, irq}, 32'h0);
        @(negedge clk);
        check("R5 irq after one cycle", {19'b0, irq}, 32'h1);

        // R3 mask keeps top bits only
        rd(4'd1, v); check("R3 mask readback", v, 32'hFFF8_0000);

        // R2 write-one-to-clear
        pulse(13'h1FFF);
        wr(4'd0, 32'h8000_0000);
        rd(4'd0, v); check("R2 clear heartbeat only", v, 32'h7FF8_0000);
        wr(4'd0, 32'h0000_0000);
        rd(4'd0, v); check("R2 zero write no effect", v, 32'h7FF8_0000);

        // R6 set wins over clear
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'hFFFF_FFFF; evt_set = 13'h0100;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; evt_set = '0;
        rd(4'd0, v); check("R6 set beats clear", v, 32'h0800_0000);

        // R7 management write
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd2, 32'h1234_5678);
        rd(4'd0, v); check("R7 mgmt event", v, 32'h0080_0000);
        // R11 unmapped read
        rd(4'd2, v); check("R11 mgmt reads zero", v, 32'h0);
        rd(4'd9, v); check("R11 unmapped reads zero", v, 32'h0);

        // R8 transmit control
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd3, 32'h0000_0000);
        rd(4'd0, v); check("R8 bit0 clear no event", v, 32'h0);
        wr(4'd3, 32'h0000_0001);
        rd(4'd0, v); check("R8 graceful-stop event", v, 32'h1000_0000);

        // R9 controller reset
        wr(4'd4, 32'h0000_0002);
        rd(4'd0, v); check("R9 bit0 clear keeps status", v, 32'h1000_0000);
        rd(4'd1, v); check("R9 bit0 clear keeps mask", v, 32'hFFF8_0000);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd4; reg_wdata = 32'h1; evt_set = 13'h1FFF;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; evt_set = '0;
        rd(4'd0, v); check("R9 status wiped", v, 32'h0);
        rd(4'd1, v); check("R9 mask wiped", v, 32'h0);
        @(negedge clk);
        check("R9 irq low", {19'b0, irq}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule